// File: doc/BRIEF.md
# Masked Vector Move and Sign-Test Unit

This unit moves a 256-bit vector to or from memory one element lane at a time, under control of a mask vector. It also reduces the sign bits of two vectors to a pair of flags. Elements are 32 or 64 bits wide. An element takes part in a transfer when the top bit of the matching mask element is 1.

On a masked load, each selected element takes the memory word and every other element becomes zero. On a masked store, byte strobes cover only the selected elements, so memory bytes outside them keep their old contents. An operation whose mask selects nothing never reaches memory and completes at once. The sign test needs no memory at all.

Control is a four-state machine:
- IDLE accepts a `start` pulse.
- REQ holds a request until memory takes it.
- RSP waits for load data.
- DONE raises `done` for one cycle and then returns to IDLE.

The transitions are:
- IDLE to REQ: a load or store with at least one element selected.
- IDLE to DONE: a sign test, a reserved op, or an empty mask.
- REQ to RSP: a load whose request memory has accepted.
- REQ to DONE: a store whose request memory has accepted.
- RSP to DONE: when the response arrives.
- DONE to IDLE: always.

Top module: `mvst_unit`

## Requirements
- R1: `op_sel` 2'b00 is a masked load, 2'b01 a masked store, 2'b10 a sign test, and 2'b11 a no-op that completes in the cycle after issue and changes nothing. `elem64`=0 selects 32-bit elements and `elem64`=1 selects 64-bit elements. Element k is selected when bit 31 of 32-bit slot k (or bit 63 of 64-bit slot k) of `vec_m` is 1.
- R2: After a masked load completes, each selected element of `load_data` equals the same element of the memory word at `addr`, and every unselected element is zero.
- R3: A masked store writes `vec_a` with `mem_req_strb` bit b set exactly when the element holding byte b is selected. Bytes of unselected elements in memory stay unchanged.
- R4: A load or store whose mask selects no element raises `done` in the cycle after issue and issues no memory request. In the load case, `load_data` becomes all zero.
- R5: A sign test sets `flag_zf` to 1 exactly when no element has both its `vec_a` sign bit and its `vec_m` sign bit set.
- R6: A sign test sets `flag_cf` to 1 exactly when no element has its `vec_a` sign bit clear and its `vec_m` sign bit set.
- R7: A sign test raises `done` in the cycle after issue and makes no memory request.
- R8: A memory request stays asserted, with the same address, strobes and direction, until `mem_req_ready`. A store completes in the cycle after acceptance, and a load completes in the cycle after `mem_rsp_valid`.
- R9: `start` is ignored while `busy` is 1, and each accepted operation produces exactly one `done` pulse.
- R10: Flags change only on a sign test, and `load_data` changes only on a load.
- R11: After reset, `busy`, `done`, `mem_req_valid`, `flag_zf`, `flag_cf` and `load_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue pulse, taken only when idle |
| op_sel | input | 2 | Operation code |
| elem64 | input | 1 | Element size: 0 = 32-bit, 1 = 64-bit |
| vec_a | input | 256 | Store data / first test operand |
| vec_m | input | 256 | Mask / second test operand |
| addr | input | 16 | Memory word address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| load_data | output | 256 | Result of the last load |
| flag_zf | output | 1 | Zero flag from the last sign test |
| flag_cf | output | 1 | Carry flag from the last sign test |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 16 | Request address |
| mem_req_strb | output | 32 | Byte strobes |
| mem_req_wdata | output | 256 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 256 | Read data |

## Verification
A wrong latched select vector shows up as wrong strobes on the request. The bench sees this as a corrupted or missing memory byte right after the store completes, or as a nonzero unselected lane in `load_data` when `done` rises. A state machine that leaves IDLE for the wrong state shows up in the issue-plus-one cycle: either `done` fails to appear for a test or empty-mask operation, or a stray memory request appears. A lost or duplicated DONE visit shows up as a `done` count that differs from the number of operations issued, within two cycles of the expected pulse.

// File: rtl/mvst_pkg.sv
package mvst_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_TEST  = 2'b10,
        OP_NOP   = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_RSP,
        ST_DONE
    } state_e;
endpackage

// File: rtl/mvst_sign_gather.sv
// Collects one sign bit per 32-bit slot; in wide mode both slots of a
// 64-bit element carry that element's top bit.
module mvst_sign_gather #(
    parameter int VEC_W  = 256,
    parameter int SLOT_W = 32,
    localparam int SLOTS = VEC_W / SLOT_W
) (
    input  logic [VEC_W-1:0] vec,
    input  logic             wide,
    output logic [SLOTS-1:0] sgn
);
    localparam int PAIR_W = 2 * SLOT_W;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign sgn[i] = wide ? vec[PAIR_W*(i/2) + PAIR_W - 1]
                             : vec[SLOT_W*i + SLOT_W - 1];
    end
endmodule

// File: rtl/mvst_lane_expand.sv
// Spreads each slot select over its bytes and its bits.
module mvst_lane_expand #(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = 32,
    localparam int SLOT_B = SLOT_W / 8
) (
    input  logic [SLOTS-1:0]        sel,
    output logic [SLOTS*SLOT_B-1:0] strb,
    output logic [SLOTS*SLOT_W-1:0] bitmask
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_lane
        assign strb[i*SLOT_B +: SLOT_B]    = {SLOT_B{sel[i]}};
        assign bitmask[i*SLOT_W +: SLOT_W] = {SLOT_W{sel[i]}};
    end
endmodule

// File: rtl/mvst_unit.sv
module mvst_unit
    import mvst_pkg::*;
#(
    parameter int VEC_W  = 256,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_sel,
    input  logic              elem64,
    input  logic [VEC_W-1:0]  vec_a,
    input  logic [VEC_W-1:0]  vec_m,
    input  logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done,
    output logic [VEC_W-1:0]  load_data,
    output logic              flag_zf,
    output logic              flag_cf,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [VEC_W/8-1:0] mem_req_strb,
    output logic [VEC_W-1:0]  mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [VEC_W-1:0]  mem_rsp_data
);
    localparam int SLOT_W = 32;
    localparam int SLOTS  = VEC_W / SLOT_W;
    localparam int STRB_W = VEC_W / 8;

    state_e             state_q, state_d;
    op_e                op_in, op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [SLOTS-1:0]   sel_in, sgn_a, sel_q;
    logic [VEC_W-1:0]   wdata_q, load_q, lane_bits;
    logic [STRB_W-1:0]  lane_strb;
    logic               zf_q, cf_q;
    logic               issue, move_op;

    assign op_in   = op_e'(op_sel);
    assign issue   = (state_q == ST_IDLE) && start;
    assign move_op = (op_in == OP_LOAD) || (op_in == OP_STORE);

    mvst_sign_gather #(.VEC_W(VEC_W), .SLOT_W(SLOT_W)) u_mask_sgn (
        .vec(vec_m), .wide(elem64), .sgn(sel_in)
    );
    mvst_sign_gather #(.VEC_W(VEC_W), .SLOT_W(SLOT_W)) u_data_sgn (
        .vec(vec_a), .wide(elem64), .sgn(sgn_a)
    );
    mvst_lane_expand #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_expand (
        .sel(sel_q), .strb(lane_strb), .bitmask(lane_bits)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (move_op && |sel_in) ? ST_REQ : ST_DONE;
            ST_REQ:  if (mem_req_ready) state_d = (op_q == OP_LOAD) ? ST_RSP : ST_DONE;
            ST_RSP:  if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operation context and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_NOP;
            addr_q  <= '0;
            sel_q   <= '0;
            wdata_q <= '0;
            load_q  <= '0;
            zf_q    <= 1'b0;
            cf_q    <= 1'b0;
        end else begin
            if (issue) begin
                op_q    <= op_in;
                addr_q  <= addr;
                sel_q   <= sel_in;
                wdata_q <= vec_a;
                if (op_in == OP_TEST) begin
                    zf_q <= ~|(sgn_a & sel_in);
                    cf_q <= ~|(~sgn_a & sel_in);
                end
                if (op_in == OP_LOAD && !(|sel_in)) load_q <= '0;
            end
            if (state_q == ST_RSP && mem_rsp_valid)
                load_q <= mem_rsp_data & lane_bits;
        end
    end

    // outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        done          = (state_q == ST_DONE);
        mem_req_valid = (state_q == ST_REQ);
        mem_req_write = (op_q == OP_STORE);
        mem_req_addr  = addr_q;
        mem_req_strb  = lane_strb;
        mem_req_wdata = wdata_q;
        load_data     = load_q;
        flag_zf       = zf_q;
        flag_cf       = cf_q;
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_strb) && $stable(mem_req_write)));
    // R4
    no_empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_strb != '0));
    // R7
    test_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op_in == OP_TEST) |=> (done && !mem_req_valid));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && op_in == OP_TEST) |=> $stable({flag_zf, flag_cf}));
    for (genvar g = 0; g < SLOTS; g++) begin : g_strb_chk
        // R3
        strb_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mem_req_valid |-> (mem_req_strb[g*4 +: 4] == 4'h0 || mem_req_strb[g*4 +: 4] == 4'hF));
    end
endmodule

// File: tb/tb_mvst_unit.sv
module tb_mvst_unit;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [255:0] ld;
        logic         zf;
        logic         cf;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic         elem64 = 1'b0;
    logic [255:0] vec_a = '0, vec_m = '0;
    logic [15:0]  addr = '0;
    logic         busy, done, flag_zf, flag_cf;
    logic [255:0] load_data;
    logic         mem_req_valid, mem_req_write;
    logic         mem_req_ready = 1'b0;
    logic [15:0]  mem_req_addr;
    logic [31:0]  mem_req_strb;
    logic [255:0] mem_req_wdata;
    logic         mem_rsp_valid = 1'b0;
    logic [255:0] mem_rsp_data = '0;

    int n_chk = 0, n_bad = 0, done_cnt = 0, req_cnt = 0, stall = 0;
    bit finished = 0;
    exp_t sb[$];
    logic [255:0] mem_model [16];
    logic [255:0] exp_mem [16];
    logic [255:0] exp_ld = '0;
    logic exp_zf = 0, exp_cf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mvst_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .elem64(elem64),
        .vec_a(vec_a), .vec_m(vec_m), .addr(addr), .busy(busy), .done(done),
        .load_data(load_data), .flag_zf(flag_zf), .flag_cf(flag_cf),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_strb(mem_req_strb), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pick(input logic [255:0] v, input logic e64);
        logic [7:0] p;
        for (int j = 0; j < 8; j++) p[j] = e64 ? v[(j/2)*64 + 63] : v[j*32 + 31];
        return p;
    endfunction

    // memory model: stalls ready by 'stall' cycles, answers reads one cycle after acceptance
    bit hs = 0, rsp_pend = 0;
    int wait_cnt = 0;
    logic [255:0] rsp_line = '0;
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (rsp_pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rsp_line;
            rsp_pend      = 0;
        end
        if (hs) begin
            mem_req_ready = 1'b0;
            hs = 0;
            wait_cnt = 0;
        end else if (mem_req_valid) begin
            if (wait_cnt < stall) begin
                wait_cnt++;
                mem_req_ready = 1'b0;
            end else begin
                mem_req_ready = 1'b1;
                hs = 1;
                req_cnt++;
                if (mem_req_write) begin
                    for (int b = 0; b < 32; b++)
                        if (mem_req_strb[b]) mem_model[mem_req_addr[3:0]][b*8 +: 8] = mem_req_wdata[b*8 +: 8];
                end else begin
                    rsp_line = mem_model[mem_req_addr[3:0]];
                    rsp_pend = 1;
                end
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_cnt++;
            if (sb.size() == 0) begin
                check(0, "R9 unexpected done", 256'd1, 256'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(load_data === e.ld, {e.tag, " load_data"}, load_data, e.ld);
                check(flag_zf === e.zf, {e.tag, " zf"}, {255'd0, flag_zf}, {255'd0, e.zf});
                check(flag_cf === e.cf, {e.tag, " cf"}, {255'd0, flag_cf}, {255'd0, e.cf});
            end
        end
    end

    task automatic run_op(input logic [1:0] op, input logic e64, input logic [255:0] a,
                          input logic [255:0] m, input logic [3:0] line, input int stl,
                          input bit poke, input string tag);
        logic [7:0] sm, sa;
        bit fast;
        int d0, r0;
        exp_t e;
        sm = pick(m, e64);
        sa = pick(a, e64);
        fast = !(op == 2'b00 || op == 2'b01) || (sm == 8'd0);
        if (op == 2'b00) begin
            for (int j = 0; j < 8; j++)
                exp_ld[j*32 +: 32] = sm[j] ? exp_mem[line][j*32 +: 32] : 32'd0;
        end else if (op == 2'b01) begin
            for (int j = 0; j < 8; j++)
                if (sm[j]) exp_mem[line][j*32 +: 32] = a[j*32 +: 32];
        end else if (op == 2'b10) begin
            exp_zf = ((sa & sm) == 8'd0);
            exp_cf = ((~sa & sm) == 8'd0);
        end
        e.ld = exp_ld; e.zf = exp_zf; e.cf = exp_cf; e.tag = tag;
        sb.push_back(e);
        stall = stl;
        d0 = done_cnt;
        r0 = req_cnt;
        @(negedge clk);
        start = 1'b1; op_sel = op; elem64 = e64; vec_a = a; vec_m = m; addr = {12'd0, line};
        @(negedge clk);
        start = 1'b0;
        if (fast) check(done === 1'b1, {tag, " done one cycle after issue"}, {255'd0, done}, 256'd1);
        if (poke) begin
            start = 1'b1; op_sel = 2'b10; vec_a = '1; vec_m = '1;
            @(negedge clk);
            start = 1'b0;
        end
        do begin
            @(negedge clk);
            #1;
        end while (done_cnt == d0);
        repeat (2) @(negedge clk);
        #1;
        check(done_cnt == d0 + 1, {tag, " R9 single done"}, 256'(done_cnt), 256'(d0 + 1));
        check(req_cnt == r0 + (fast ? 0 : 1), {tag, " request count"}, 256'(req_cnt), 256'(r0 + (fast ? 0 : 1)));
        if (op == 2'b01)
            check(mem_model[line] === exp_mem[line], {tag, " memory image"}, mem_model[line], exp_mem[line]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [255:0] alt32, ones, hi64, lo_only;
        for (int i = 0; i < 16; i++)
            for (int b = 0; b < 32; b++) begin
                mem_model[i][b*8 +: 8] = 8'(i*37 + b*11 + 5);
                exp_mem[i][b*8 +: 8]   = 8'(i*37 + b*11 + 5);
            end
        alt32 = '0; hi64 = '0; lo_only = '0; ones = '1;
        for (int j = 0; j < 8; j += 2) alt32[j*32 + 31] = 1'b1;
        hi64[63] = 1'b1; hi64[255] = 1'b1;
        for (int j = 0; j < 4; j++) lo_only[j*64 + 31] = 1'b1;

        repeat (3) @(negedge clk);
        // R11 reset state
        check({busy, done, mem_req_valid, flag_zf, flag_cf} === 5'b0, "R11 reset controls",
              {251'd0, busy, done, mem_req_valid, flag_zf, flag_cf}, 256'd0);
        check(load_data === '0, "R11 reset load_data", load_data, 256'd0);
        rst_n = 1'b1;

        run_op(2'b00, 1'b0, '0, alt32, 4'd1, 0, 0, "R2 load 32 alternating");
        run_op(2'b00, 1'b1, '0, hi64, 4'd2, 2, 0, "R2 R8 load 64 ends stalled");
        run_op(2'b01, 1'b0, {8{32'hA5C3_0F1E}}, alt32, 4'd3, 1, 0, "R3 R10 store 32");
        run_op(2'b01, 1'b1, {4{64'h1122_3344_5566_7788}}, hi64, 4'd4, 3, 0, "R3 R8 store 64");
        run_op(2'b00, 1'b0, '0, ones, 4'd3, 0, 0, "R2 load back full");
        run_op(2'b00, 1'b0, '0, '0, 4'd5, 0, 0, "R4 empty load");
        run_op(2'b01, 1'b0, ones, '0, 4'd5, 0, 0, "R4 empty store");
        run_op(2'b10, 1'b0, alt32, ones, 4'd0, 0, 0, "R5 R6 R7 test overlap");
        run_op(2'b10, 1'b0, '0, alt32, 4'd0, 0, 0, "R5 R6 test clear first");
        run_op(2'b10, 1'b1, ones, lo_only, 4'd0, 0, 0, "R1 R5 R6 test 64 ignores bit31");
        run_op(2'b00, 1'b1, '0, lo_only, 4'd6, 0, 0, "R1 R4 load 64 no selected");
        run_op(2'b10, 1'b0, ones, ones, 4'd0, 0, 0, "R5 R6 test all set");
        run_op(2'b00, 1'b0, '0, hi64, 4'd7, 3, 1, "R9 start ignored while busy");
        run_op(2'b11, 1'b0, ones, ones, 4'd7, 0, 0, "R1 R10 reserved op no change");
        run_op(2'b01, 1'b0, '0, ones, 4'd8, 0, 0, "R3 full store");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule